// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a twelve-pin general-purpose I/O controller on a plain 32-bit register bus. Every pin has an output latch and a direction bit. The direction bit decides whether the pin drives the latched value or is only observed. Each incoming pin level passes through a two-stage synchronizer, and the synchronized levels can be read from a dedicated register.

Each pin has its own event detector. A three-bit mode selects the event: a falling edge, a rising edge, either edge, a high level or a low level. An event sets a sticky status bit, but only when the pin's enable bit is 1. Software clears status by writing ones to an acknowledge word. The mask is changed through two words: one sets mask bits and the other clears them. A display word returns the unmasked pending status, and the single interrupt line is the OR of that word. Writing 1 to the soft-reset word holds every register at its default until a 0 is written.

Register words are 4 bytes apart. The word index is `bus_addr[5:2]`:

| Index | Word |
|---|---|
| 0 | enable |
| 1 | status |
| 2 | display |
| 3 | acknowledge |
| 4 | mask-set |
| 5 | mask-clear |
| 6 | output latch |
| 7 | input level |
| 8 | direction |
| 9 | mode word 0 |
| 10 | mode word 1 |
| 11–14 | unused |
| 15 | soft reset |

Reads are registered and return data one clock after `bus_rd`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After `rst_n` is held low with the pins low, every register word reads 0, and `irq`, `pin_oe` and `pin_out` are all 0.
- R2: The direction word (index 8) drives `pin_oe` and the output-latch word (index 6) drives `pin_out`. Both change on the clock edge that takes the write, and both read back as written.
- R3: The input word (index 7) returns each pin's level after a two-flop synchronizer. A read issued three or more cycles after an input change returns the new level.
- R4: Pin p has a 3-bit mode at bit 4×p of mode word 0 (index 9) for p<8, and at bit 4×(p−8) of mode word 1 (index 10) for p≥8. The fourth bit of each field and every bit above pin 11's field read 0.
- R5: With mode bit 2 clear, mode 0 detects falling edges and mode 1 detects rising edges. The opposite edge has no effect. A status bit rises on the third clock edge after the input changes.
- R6: With mode bit 2 set (values 4–7), both edges set status.
- R7: Mode 3 (high level) and mode 2 (low level) keep setting status while the level lasts, so an acknowledge only sticks once the level is gone.
- R8: Status sets only for pins whose enable bit (index 0) is 1.
- R9: Each 1 written to mask-set (index 4) sets a mask bit, and each 1 written to mask-clear (index 5) clears one. Zero bits leave the mask alone. Reading index 4 returns the mask.
- R10: A 1 written to the acknowledge word (index 3) clears that status bit. Display (index 2) reads status AND NOT mask. `irq` is the OR of display.
- R11: If an event and an acknowledge of the same pin land on the same clock edge, the status bit stays set.
- R12: Writing 1 to the soft-reset word (index 15, bit 0) returns all other state to defaults from the next cycle on, and keeps it there. That word reads back its bit, and writing 0 releases the block.
- R13: Only the low 12 bits of the per-pin words are stored. Writes to status, display, input and the unused words have no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address; bits 5:2 select the word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 12 | Pin levels from the pads |
| pin_out | output | 12 | Output latch value |
| pin_oe | output | 12 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Two things can hit the same status bit on the same clock edge: an acknowledge write and a freshly detected event. To provoke this, the bench times an input toggle on an either-edge pin so that its detection falls exactly on the edge where an acknowledge for that pin is taken. The status must then read back as set. A level-mode pin gives a second version of the same collision, because the level re-asserts status on every edge, and an acknowledge issued while the level is present must not stick.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register indices and mode encodings for the GPIO controller.
// Assumes word-addressed registers four bytes apart on a 32-bit bus.
package gpio_irq_pkg;

    // Register word indices (byte address bits 5:2).
    typedef enum logic [3:0] {
        RI_ENABLE = 4'd0,
        RI_STATUS = 4'd1,
        RI_SHOW   = 4'd2,
        RI_ACK    = 4'd3,
        RI_MSET   = 4'd4,
        RI_MCLR   = 4'd5,
        RI_DOUT   = 4'd6,
        RI_DIN    = 4'd7,
        RI_DIR    = 4'd8,
        RI_MODE0  = 4'd9,
        RI_MODE1  = 4'd10,
        RI_SPARE0 = 4'd11,
        RI_SPARE1 = 4'd12,
        RI_SPARE2 = 4'd13,
        RI_SPARE3 = 4'd14,
        RI_SRST   = 4'd15
    } reg_idx_e;

    // Mode field geometry.
    localparam int MODE_BITS       = 3;
    localparam int FIELD_STRIDE    = 4;
    localparam int FIELDS_PER_WORD = 8;

    // Mode encodings used when bit 2 is clear.
    localparam logic [1:0] MD_FALL = 2'd0;
    localparam logic [1:0] MD_RISE = 2'd1;
    localparam logic [1:0] MD_LOW  = 2'd2;
    localparam logic [1:0] MD_HIGH = 2'd3;

    // Bit that selects either-edge detection.
    localparam int MD_BOTH_BIT = 2;

endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop input synchronizer plus a one-cycle history stage.
// Assumes pin_raw is asynchronous to clk. 'clr' is a synchronous soft clear.
module gpio_sync #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] prior
);

    logic [WIDTH-1:0] stage1;

    // Capture the raw pins, settle them, and keep the previous settled value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stage1 <= '0;
            level  <= '0;
            prior  <= '0;
        end else begin
            stage1 <= pin_raw;
            level  <= stage1;
            prior  <= level;
        end
    end

endmodule

// File: rtl/gpio_event_detect.sv
// Module: per-pin event decoder that turns the mode, level and history into a hit.
// Assumes level/prior come from the synchronizer. Purely combinational.
module gpio_event_detect
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0]                level,
    input  logic [WIDTH-1:0]                prior,
    input  logic [WIDTH-1:0][MODE_BITS-1:0] mode,
    output logic [WIDTH-1:0]                hit
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic rise, fall;

        // Edge terms for this pin.
        assign rise = level[p] & ~prior[p];
        assign fall = ~level[p] & prior[p];

        // Select the event for the programmed mode.
        always_comb begin
            if (mode[p][MD_BOTH_BIT]) begin
                hit[p] = rise | fall;
            end else begin
                case (mode[p][1:0])
                    MD_FALL: hit[p] = fall;
                    MD_RISE: hit[p] = rise;
                    MD_LOW:  hit[p] = ~level[p];
                    default: hit[p] = level[p];
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_irq_state.sv
// Module: enable, mask and sticky status registers and the combined interrupt.
// Assumes at most one of the write strobes is active per cycle (one bus address).
// When an event and an acknowledge meet, the set wins.
module gpio_irq_state #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] hit,
    input  logic             en_we,
    input  logic             mset_we,
    input  logic             mclr_we,
    input  logic             ack_we,
    input  logic [WIDTH-1:0] wbits,
    output logic [WIDTH-1:0] enable,
    output logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] shown,
    output logic             irq
);

    logic [WIDTH-1:0] ack_bits;

    // Acknowledge bits apply only on a write to the acknowledge word.
    assign ack_bits = ack_we ? wbits : '0;

    // Enable register: full overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            enable <= '0;
        end else if (en_we) begin
            enable <= wbits;
        end
    end

    // Mask register: ones set through one word, ones clear through the other.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask <= '0;
        end else if (mset_we) begin
            mask <= mask | wbits;
        end else if (mclr_we) begin
            mask <= mask & ~wbits;
        end
    end

    // Status register: acknowledge clears, an enabled event sets, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            status <= '0;
        end else begin
            status <= (status & ~ack_bits) | (hit & enable);
        end
    end

    assign shown = status & ~mask;
    assign irq   = |shown;

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the GPIO controller. Decodes the register bus, holds the output,
// direction, mode and soft-reset registers, and instantiates the synchronizer,
// event detector and interrupt state.
// Assumes NUM_PINS <= 16 (two mode words) and a registered one-cycle read.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 12,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int PAD_W = DATA_W - NUM_PINS;

    logic [IDX_W-1:0]                  word_idx;
    logic [NUM_PINS-1:0]               wbits;
    logic                              srst_q;
    logic [NUM_PINS-1:0]               dout_q;
    logic [NUM_PINS-1:0]               dir_q;
    logic [NUM_PINS-1:0][MODE_BITS-1:0] mode_q;
    logic [NUM_PINS-1:0]               level, prior, hit;
    logic [NUM_PINS-1:0]               irq_enable, irq_mask, irq_status, irq_shown;
    logic [DATA_W-1:0]                 mode_word0, mode_word1;
    logic [DATA_W-1:0]                 rd_mux;
    logic                              unused_bits;

    assign word_idx    = bus_addr[ADDR_W-1:2];
    assign wbits       = bus_wdata[NUM_PINS-1:0];
    assign unused_bits = ^{bus_addr[1:0]};

    // Write strobe for one register word.
    function automatic logic wr_hit(input logic we, input logic [IDX_W-1:0] w,
                                    input reg_idx_e r);
        return we && (w == IDX_W'(r));
    endfunction

    // Soft-reset control bit; only the hard reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
        end else if (wr_hit(bus_wr, word_idx, RI_SRST)) begin
            srst_q <= bus_wdata[0];
        end
    end

    // Output latch register.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            dout_q <= '0;
        end else if (wr_hit(bus_wr, word_idx, RI_DOUT)) begin
            dout_q <= wbits;
        end
    end

    // Direction register.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            dir_q <= '0;
        end else if (wr_hit(bus_wr, word_idx, RI_DIR)) begin
            dir_q <= wbits;
        end
    end

    // Mode fields: each pin takes its 3-bit slice of its mode word.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
        localparam int WSEL = p / FIELDS_PER_WORD;
        localparam int SLOT = p % FIELDS_PER_WORD;
        localparam reg_idx_e MREG = (WSEL == 0) ? RI_MODE0 : RI_MODE1;

        // Load this pin's mode on a write to its mode word.
        always_ff @(posedge clk) begin
            if (!rst_n || srst_q) begin
                mode_q[p] <= '0;
            end else if (wr_hit(bus_wr, word_idx, MREG)) begin
                mode_q[p] <= bus_wdata[SLOT*FIELD_STRIDE +: MODE_BITS];
            end
        end
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    gpio_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst_q),
        .pin_raw (pin_in),
        .level   (level),
        .prior   (prior)
    );

    gpio_event_detect #(
        .WIDTH (NUM_PINS)
    ) u_detect (
        .level (level),
        .prior (prior),
        .mode  (mode_q),
        .hit   (hit)
    );

    gpio_irq_state #(
        .WIDTH (NUM_PINS)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst_q),
        .hit     (hit),
        .en_we   (wr_hit(bus_wr, word_idx, RI_ENABLE)),
        .mset_we (wr_hit(bus_wr, word_idx, RI_MSET)),
        .mclr_we (wr_hit(bus_wr, word_idx, RI_MCLR)),
        .ack_we  (wr_hit(bus_wr, word_idx, RI_ACK)),
        .wbits   (wbits),
        .enable  (irq_enable),
        .mask    (irq_mask),
        .status  (irq_status),
        .shown   (irq_shown),
        .irq     (irq)
    );

    // Pack the mode fields back into their two words for reading.
    always_comb begin
        mode_word0 = '0;
        mode_word1 = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (p < FIELDS_PER_WORD) begin
                mode_word0[(p % FIELDS_PER_WORD)*FIELD_STRIDE +: MODE_BITS] = mode_q[p];
            end else begin
                mode_word1[(p % FIELDS_PER_WORD)*FIELD_STRIDE +: MODE_BITS] = mode_q[p];
            end
        end
    end

    // Read multiplexer; write-only and unused words return zero.
    always_comb begin
        rd_mux = '0;
        case (word_idx)
            IDX_W'(RI_ENABLE): rd_mux = {{PAD_W{1'b0}}, irq_enable};
            IDX_W'(RI_STATUS): rd_mux = {{PAD_W{1'b0}}, irq_status};
            IDX_W'(RI_SHOW):   rd_mux = {{PAD_W{1'b0}}, irq_shown};
            IDX_W'(RI_MSET):   rd_mux = {{PAD_W{1'b0}}, irq_mask};
            IDX_W'(RI_DOUT):   rd_mux = {{PAD_W{1'b0}}, dout_q};
            IDX_W'(RI_DIN):    rd_mux = {{PAD_W{1'b0}}, level};
            IDX_W'(RI_DIR):    rd_mux = {{PAD_W{1'b0}}, dir_q};
            IDX_W'(RI_MODE0):  rd_mux = mode_word0;
            IDX_W'(RI_MODE1):  rd_mux = mode_word1;
            IDX_W'(RI_SRST):   rd_mux = {{(DATA_W-1){1'b0}}, srst_q};
            default:           rd_mux = '0;
        endcase
    end

    // Registered read data, updated when a read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module: assertion checker bound to gpio_irq_ctrl. It watches the bus and the
// interrupt state and checks where each state change may come from.
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 12,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NUM_PINS-1:0] status,
    input logic [NUM_PINS-1:0] mask,
    input logic [NUM_PINS-1:0] enable,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                srst,
    input logic                irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    widx;
    logic [NUM_PINS-1:0] wbits, ack_vec, mset_vec, mclr_vec;
    logic                dir_wr;
    logic                unused_chk;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign wbits      = bus_wdata[NUM_PINS-1:0];
    assign ack_vec    = (bus_wr && widx == IDX_W'(RI_ACK))  ? wbits : '0;
    assign mset_vec   = (bus_wr && widx == IDX_W'(RI_MSET)) ? wbits : '0;
    assign mclr_vec   = (bus_wr && widx == IDX_W'(RI_MCLR)) ? wbits : '0;
    assign dir_wr     = bus_wr && widx == IDX_W'(RI_DIR);
    assign unused_chk = ^{bus_addr[1:0], bus_wdata};

    // R10
    status_w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status) & ~status & ~$past(ack_vec)) == '0) || $past(srst)));

    // R8
    status_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(enable)) == '0));

    // R9
    mask_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & ~$past(mask) & ~$past(mset_vec)) == '0));

    // R9
    mask_clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(mask) & ~mask & ~$past(mclr_vec)) == '0) || $past(srst)));

    // R12
    srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (status == '0 && !irq && pin_oe == '0));

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(dir_wr) && !$past(srst)) |-> $stable(pin_oe));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .status    (irq_status),
    .mask      (irq_mask),
    .enable    (irq_enable),
    .pin_oe    (pin_oe),
    .srst      (srst_q),
    .irq       (irq)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 12;
    localparam int NVEC = 13;

    // Word indices as given in the requirements.
    localparam logic [3:0] W_EN = 4'd0, W_ST = 4'd1, W_SHOW = 4'd2, W_ACK = 4'd3,
                           W_MSET = 4'd4, W_MCLR = 4'd5, W_DOUT = 4'd6, W_DIN = 4'd7,
                           W_DIR = 4'd8, W_M0 = 4'd9, W_M1 = 4'd10, W_SPARE = 4'd14,
                           W_SRST = 4'd15;

    // {write index, write data, read index, expected, requirement number}
    localparam logic [75:0] VEC [NVEC] = '{
        {W_DOUT, 32'hFFFF_FFFF, W_DOUT, 32'h0000_0FFF, 4'd13}, // R13 width
        {W_DIR,  32'h0000_0A5A, W_DIR,  32'h0000_0A5A, 4'd2},  // R2 readback
        {W_M0,   32'hFFFF_FFFF, W_M0,   32'h7777_7777, 4'd4},  // R4 field bits
        {W_M1,   32'hFFFF_FFFF, W_M1,   32'h0000_7777, 4'd4},  // R4 upper word
        {W_M0,   32'h1234_5678, W_M0,   32'h1234_5670, 4'd4},  // R4 per-field
        {W_EN,   32'hFFFF_F003, W_EN,   32'h0000_0003, 4'd13}, // R13 enable width
        {W_MSET, 32'h0000_0003, W_MSET, 32'h0000_0003, 4'd9},  // R9 set
        {W_MCLR, 32'h0000_0001, W_MSET, 32'h0000_0002, 4'd9},  // R9 clear
        {W_MSET, 32'h0000_0000, W_MSET, 32'h0000_0002, 4'd9},  // R9 zero no effect
        {W_ST,   32'h0000_0FFF, W_ST,   32'h0000_0000, 4'd13}, // R13 status read-only
        {W_DIN,  32'h0000_0FFF, W_DIN,  32'h0000_0000, 4'd13}, // R13 input read-only
        {W_SHOW, 32'h0000_0FFF, W_SHOW, 32'h0000_0000, 4'd13}, // R13 display read-only
        {W_SPARE,32'h0000_0FFF, W_SPARE,32'h0000_0000, 4'd13}  // R13 unused word
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr = {idx, 2'b00};
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        bus_addr = {idx, 2'b00};
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] got;
        logic [75:0] v;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: every word reads zero after reset, and the outputs are idle.
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), got);
            chk($sformatf("R1 word %0d", i), got, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pin_oe", {20'b0, pin_oe}, 32'h0);
        chk("R1 pin_out", {20'b0, pin_out}, 32'h0);

        // R2: direction and output latch drive the pins on the write edge.
        wr(W_DIR, 32'h0F0);
        chk("R2 pin_oe", {20'b0, pin_oe}, 32'h0F0);
        wr(W_DOUT, 32'h0A0);
        chk("R2 pin_out", {20'b0, pin_out}, 32'h0A0);

        // R3 and R8: input sampling; all pins in rising mode but not enabled.
        wr(W_M0, 32'h1111_1111);
        wr(W_M1, 32'h0000_1111);
        pin_in = 12'h5A3;
        settle();
        rd(W_DIN, got);
        chk("R3 input level", got, 32'h5A3);
        rd(W_ST, got);
        chk("R8 no status when disabled", got, 32'h0);
        chk("R8 irq idle", {31'b0, irq}, 32'h0);
        pin_in = '0;
        settle();

        // Table of register write/readback vectors (R2, R4, R9, R13).
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            wr(v[75:72], v[71:40]);
            rd(v[39:36], got);
            chk($sformatf("R%0d table %0d", v[3:0], i), got, v[35:4]);
        end

        // R12: soft reset clears everything and holds it while set.
        wr(W_SRST, 32'h1);
        @(negedge clk);
        chk("R12 pin_oe cleared", {20'b0, pin_oe}, 32'h0);
        chk("R12 pin_out cleared", {20'b0, pin_out}, 32'h0);
        rd(W_SRST, got);
        chk("R12 reset word readback", got, 32'h1);
        wr(W_DIR, 32'hFFF);
        @(negedge clk);
        chk("R12 held in reset", {20'b0, pin_oe}, 32'h0);
        wr(W_SRST, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), got);
            chk($sformatf("R12 word %0d after release", i), got, 32'h0);
        end

        // Event set-up: pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 low.
        pin_in = 12'h010;
        settle();
        wr(W_M0, 32'h0002_3401);
        wr(W_EN, 32'h01F);
        settle();
        rd(W_ST, got);
        chk("R8 quiet after enable", got, 32'h0);

        // R5 rising
        pin_in = 12'h011;
        settle();
        rd(W_ST, got);
        chk("R5 rising edge", got, 32'h001);
        chk("R10 irq asserted", {31'b0, irq}, 32'h1);
        wr(W_ACK, 32'h001);
        rd(W_ST, got);
        chk("R10 acknowledge clears", got, 32'h0);

        // R5 falling: the rise is ignored, the fall is caught.
        pin_in = 12'h013;
        settle();
        rd(W_ST, got);
        chk("R5 rise ignored in falling mode", got, 32'h0);
        pin_in = 12'h011;
        settle();
        rd(W_ST, got);
        chk("R5 falling edge", got, 32'h002);
        wr(W_ACK, 32'h002);

        // R6 both edges
        pin_in = 12'h015;
        settle();
        rd(W_ST, got);
        chk("R6 rise in both mode", got, 32'h004);
        wr(W_ACK, 32'h004);
        pin_in = 12'h011;
        settle();
        rd(W_ST, got);
        chk("R6 fall in both mode", got, 32'h004);
        wr(W_ACK, 32'h004);

        // R7 level high persists until the level drops.
        pin_in = 12'h019;
        settle();
        wr(W_ACK, 32'h008);
        rd(W_ST, got);
        chk("R7 high level re-sets", got, 32'h008);
        pin_in = 12'h011;
        settle();
        wr(W_ACK, 32'h008);
        rd(W_ST, got);
        chk("R7 high level gone", got, 32'h0);

        // R7 level low
        pin_in = 12'h001;
        settle();
        wr(W_ACK, 32'h010);
        rd(W_ST, got);
        chk("R7 low level re-sets", got, 32'h010);
        pin_in = 12'h011;
        settle();
        wr(W_ACK, 32'h010);
        rd(W_ST, got);
        chk("R7 low level gone", got, 32'h0);

        // R9 and R10: the mask hides status from display and irq.
        pin_in = 12'h010;
        settle();
        pin_in = 12'h011;
        settle();
        wr(W_MSET, 32'h001);
        @(negedge clk);
        chk("R10 masked irq low", {31'b0, irq}, 32'h0);
        rd(W_SHOW, got);
        chk("R10 display masked", got, 32'h0);
        rd(W_ST, got);
        chk("R9 status kept under mask", got, 32'h001);
        wr(W_MCLR, 32'h001);
        @(negedge clk);
        chk("R9 unmask raises irq", {31'b0, irq}, 32'h1);
        rd(W_SHOW, got);
        chk("R10 display unmasked", got, 32'h001);
        wr(W_ACK, 32'h001);
        @(negedge clk);
        chk("R10 irq drops", {31'b0, irq}, 32'h0);

        // R11: an acknowledge lands on the same edge as a new event.
        pin_in = 12'h015;
        settle();
        rd(W_ST, got);
        chk("R11 setup", got, 32'h004);
        @(negedge clk);
        pin_in = 12'h011;
        @(negedge clk);
        @(negedge clk);
        bus_addr = {W_ACK, 2'b00};
        bus_wdata = 32'h004;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(W_ST, got);
        chk("R11 set wins over clear", got, 32'h004);
        wr(W_ACK, 32'h004);
        rd(W_ST, got);
        chk("R11 later clear works", got, 32'h0);

        // R12: soft reset during activity.
        wr(W_DIR, 32'hFFF);
        pin_in = 12'h015;
        settle();
        chk("R12 pre irq", {31'b0, irq}, 32'h1);
        wr(W_SRST, 32'h1);
        @(negedge clk);
        chk("R12 irq cleared", {31'b0, irq}, 32'h0);
        chk("R12 pin_oe cleared live", {20'b0, pin_oe}, 32'h0);
        wr(W_SRST, 32'h0);
        settle();
        rd(W_ST, got);
        chk("R12 status cleared", got, 32'h0);
        rd(W_EN, got);
        chk("R12 enable cleared", got, 32'h0);
        rd(W_M0, got);
        chk("R12 mode cleared", got, 32'h0);
        rd(W_DIN, got);
        chk("R3 input after release", got, 32'h015);

        finish_run();
    end

endmodule